// File: doc/BRIEF.md
# SMBus Register Slave with Packet Error Checking

This block is a register-access target on a two-wire open-drain serial bus. It samples the clock and data lines and finds start and stop conditions. It then answers a fixed 7-bit device address and takes a command byte that names a 16-bit register. It handles three host messages: a word write, a word read through a repeated start, and a block read that returns a byte count before the data. Every message may end with an optional CRC-8 check byte.

On a host write, the word goes to the register-file port when the message ends. The word is dropped if a check byte arrived and did not match the local CRC. In that case the slave refuses the check byte and shows an error code. On reads the slave puts the CRC after its data, for a host that keeps clocking.

Two writes in a row form an unlock sequence. The first moves the block into a calibration state. The second, if it is the very next committed write, asks for a device reset and returns the block to normal.

Top module: `smb_pec_slave`

## Requirements
- R1: A start is a falling data line while the clock is high, and a stop is a rising data line while the clock is high, both judged on the synchronised lines. A message is only decoded after a start. A stop that comes before a complete word discards the word.
- R2: An address byte whose upper seven bits equal 0x0B is acknowledged, with bit 0 as the direction (0 = write, 1 = read). Any other address is refused, and the slave leaves the data line alone until the next start.
- R3: A word write is address, command, low byte, high byte, each sent MSB first. At the stop, reg_we pulses for one cycle with reg_addr equal to the command and reg_wdata equal to {high, low}.
- R4: If one byte follows the high byte, it is compared with a CRC-8 (polynomial 0x07, initial value 0x00) over the address, command, low and high bytes. A match is acknowledged and the word is committed at the stop.
- R5: A mismatching check byte is refused and the word is not committed. err_code then reads 1 until the next start, and a start clears it to 0.
- R6: A word read is a write-address byte, the command, a repeated start and a read-address byte. The slave then returns the low byte and then the high byte of reg_rdata. A third byte, if clocked, is the CRC-8 over all five earlier bytes, both address bytes included.
- R7: A command with bit 7 set selects the block form of the read. The slave returns a count of 2, then the low byte, the high byte and the CRC-8.
- R8: A read-address byte that follows no command in the same message is refused, and err_code reads 2.
- R9: The slave only pulls the data line low (sda_oe = 1), and it starts driving only while the clock is low.
- R10: A committed write of 0x0653 to register 0x00 sets cal_mode. If the next committed write is 0x0000 to register 0x5E, dev_rst pulses for one cycle and cal_mode clears.
- R11: Any other committed write while cal_mode is set clears cal_mode without a dev_rst pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received |
| sda_oe | output | 1 | 1 pulls the data line low |
| reg_addr | output | 8 | Register index (the last command byte) |
| reg_wdata | output | 16 | Word to write |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 16 | Read word for reg_addr |
| err_code | output | 2 | 0 none, 1 check-byte mismatch, 2 read without command |
| cal_mode | output | 1 | Calibration state of the unlock sequence |
| dev_rst | output | 1 | One-cycle device reset request |

## Verification
A wrong bit counter or message phase shows at the ports within one byte time. The acknowledge slot moves, or the data line is driven while the host expects it released, so the host's next acknowledge sample reads the wrong value. A CRC accumulator that was cleared or updated at the wrong moment shows at the next check byte. A write with a good check byte is then refused, or the CRC the slave returns differs from the bench's own value. Unlock state that is wrong shows on the following committed write, as a missing or extra dev_rst pulse.

// File: rtl/smb_pkg.sv
// Shared types and helpers for the bus register slave.
// Assumes bytes move MSB first and the check code is CRC-8, polynomial 0x07.
package smb_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;
    localparam logic [BYTE_W-1:0] CRC_POLY = 8'h07;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_CMD,
        PH_WR,
        PH_RD
    } phase_t;

    typedef enum logic [1:0] {
        ERR_NONE  = 2'd0,
        ERR_PEC   = 2'd1,
        ERR_NOCMD = 2'd2
    } err_t;

    // One byte folded into the running CRC, one data bit at a time.
    function automatic logic [BYTE_W-1:0] crc8_step(input logic [BYTE_W-1:0] c,
                                                    input logic [BYTE_W-1:0] d);
        logic [BYTE_W-1:0] r;
        logic fb;
        r = c;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            fb = r[BYTE_W-1] ^ d[i];
            r  = {r[BYTE_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
        return r;
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
// Brings the two bus lines into the clock domain and finds edges and bus
// conditions on the synchronised values.
// Assumes both lines idle high; the flops reset to 1 so no false start appears.
module smb_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [SYNC_STAGES-1:0] scl_ff;
    logic [SYNC_STAGES-1:0] sda_ff;
    logic scl_q;
    logic sda_q;

    // Synchroniser chains plus one-cycle history of the settled values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
            scl_q  <= scl_s;
            sda_q  <= sda_s;
        end
    end

    assign scl_s    = scl_ff[SYNC_STAGES-1];
    assign sda_s    = sda_ff[SYNC_STAGES-1];
    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/smb_crc8_acc.sv
// Running CRC-8 over the bytes of one message.
// Assumes clr and en are never needed in the same cycle; clr wins if they are.
module smb_crc8_acc
    import smb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] crc
);
    // Clear at message boundaries, fold in each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n)   crc <= '0;
        else if (clr) crc <= '0;
        else if (en)  crc <= crc8_step(crc, din);
    end

endmodule

// File: rtl/smb_reset_unlock.sv
// Two-write unlock: a key write enters calibration, and the very next write
// decides between a reset request and a plain abort.
// Assumes we is a single-cycle strobe per committed write.
module smb_reset_unlock #(
    parameter int                AW       = 8,
    parameter int                DW       = 16,
    parameter logic [AW-1:0]     CAL_REG  = 8'h00,
    parameter logic [DW-1:0]     CAL_KEY  = 16'h0653,
    parameter logic [AW-1:0]     EXIT_REG = 8'h5E,
    parameter logic [DW-1:0]     EXIT_KEY = 16'h0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    output logic          cal_mode,
    output logic          dev_rst
);
    // Track the calibration state and raise the reset pulse on the exit write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cal_mode <= 1'b0;
            dev_rst  <= 1'b0;
        end else begin
            dev_rst <= 1'b0;
            if (we) begin
                if (!cal_mode) begin
                    cal_mode <= (addr == CAL_REG) && (data == CAL_KEY);
                end else begin
                    cal_mode <= 1'b0;
                    dev_rst  <= (addr == EXIT_REG) && (data == EXIT_KEY);
                end
            end
        end
    end

    // R10: a reset request only ever follows the calibration state.
    a_r10_rst_needs_cal: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rst |-> $past(cal_mode));

    // R10: the reset request lasts a single cycle.
    a_r10_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rst |=> !dev_rst);

endmodule

// File: rtl/smb_pec_slave.sv
// Bus register slave: address match, command, word write, word read and block
// read, each with an optional trailing CRC-8 byte, plus the unlock sequence.
// Assumes the host changes data only while the clock is low, apart from start
// and stop, and that each bus level holds for several system clocks.
module smb_pec_slave
    import smb_pkg::*;
#(
    parameter logic [6:0]        DEV_ADDR    = 7'h0B,
    parameter int                SYNC_STAGES = 2,
    parameter int                BLK_BIT     = 7,
    parameter logic [BYTE_W-1:0] CAL_REG     = 8'h00,
    parameter logic [WORD_W-1:0] CAL_KEY     = 16'h0653,
    parameter logic [BYTE_W-1:0] EXIT_REG    = 8'h5E,
    parameter logic [WORD_W-1:0] EXIT_KEY    = 16'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] reg_addr,
    output logic [WORD_W-1:0] reg_wdata,
    output logic              reg_we,
    input  logic [WORD_W-1:0] reg_rdata,
    output logic [1:0]        err_code,
    output logic              cal_mode,
    output logic              dev_rst
);
    localparam logic [BYTE_W-1:0] BLK_COUNT = BYTE_W'(WORD_W / BYTE_W);

    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

    phase_t            phase;
    logic [3:0]        bitc;
    logic [BYTE_W-1:0] rx;
    logic [BYTE_W-1:0] cmd;
    logic              have_cmd;
    logic [1:0]        wcnt;
    logic [BYTE_W-1:0] dlo, dhi;
    logic              pec_ok;
    logic [WORD_W-1:0] rd_word;
    logic              blk;
    logic [2:0]        tx_idx;
    logic              tx_started;
    logic              oe;
    err_t              err;
    logic              we_q;

    logic              crc_clr, crc_en;
    logic [BYTE_W-1:0] crc_din, crc;
    logic [BYTE_W-1:0] tx_byte;
    logic [2:0]        pec_pos;
    logic              addr_hit;

    smb_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    smb_crc8_acc u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .en    (crc_en),
        .din   (crc_din),
        .crc   (crc)
    );

    assign addr_hit = (rx[BYTE_W-1:1] == DEV_ADDR);

    // Byte to return for the current read position: count, data, then CRC.
    always_comb begin
        pec_pos = blk ? 3'd3 : 3'd2;
        tx_byte = '1;
        if (tx_idx == pec_pos) begin
            tx_byte = crc;
        end else if (tx_idx < pec_pos) begin
            if (blk && tx_idx == 3'd0)                 tx_byte = BLK_COUNT;
            else if (tx_idx == (blk ? 3'd1 : 3'd0))    tx_byte = rd_word[BYTE_W-1:0];
            else                                       tx_byte = rd_word[WORD_W-1:BYTE_W];
        end
    end

    // Decide which bytes enter the CRC and when it restarts.
    always_comb begin
        crc_clr = stop_ev || (start_ev && !(phase == PH_WR && wcnt == 2'd0));
        crc_en  = 1'b0;
        crc_din = rx;
        if (scl_fall && bitc == 4'd8) begin
            case (phase)
                PH_ADDR: crc_en = addr_hit;
                PH_CMD:  crc_en = 1'b1;
                PH_WR:   crc_en = (wcnt < 2'd2);
                default: crc_en = 1'b0;
            endcase
        end else if (scl_rise && bitc == 4'd8 && phase == PH_RD && tx_started) begin
            crc_en  = 1'b1;
            crc_din = tx_byte;
        end
    end

    // Message sequencer: bit counting, acknowledge, data return and commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            bitc       <= '0;
            rx         <= '0;
            cmd        <= '0;
            have_cmd   <= 1'b0;
            wcnt       <= '0;
            dlo        <= '0;
            dhi        <= '0;
            pec_ok     <= 1'b0;
            rd_word    <= '0;
            blk        <= 1'b0;
            tx_idx     <= '0;
            tx_started <= 1'b0;
            oe         <= 1'b0;
            err        <= ERR_NONE;
            we_q       <= 1'b0;
        end else begin
            we_q <= 1'b0;
            if (start_ev) begin
                have_cmd   <= (phase == PH_WR) && (wcnt == 2'd0);
                phase      <= PH_ADDR;
                bitc       <= '0;
                oe         <= 1'b0;
                err        <= ERR_NONE;
                tx_idx     <= '0;
                tx_started <= 1'b0;
            end else if (stop_ev) begin
                if (phase == PH_WR && (wcnt == 2'd2 || (wcnt == 2'd3 && pec_ok)))
                    we_q <= 1'b1;
                phase    <= PH_IDLE;
                oe       <= 1'b0;
                have_cmd <= 1'b0;
            end else if (scl_rise && phase != PH_IDLE) begin
                if (bitc < 4'd8) begin
                    rx   <= {rx[BYTE_W-2:0], sda_s};
                    bitc <= bitc + 4'd1;
                end else if (bitc == 4'd8) begin
                    bitc <= 4'd9;
                    if (phase == PH_RD && tx_started) begin
                        if (sda_s) phase  <= PH_IDLE;
                        else       tx_idx <= tx_idx + 3'd1;
                    end
                end
            end else if (scl_fall && phase != PH_IDLE) begin
                case (bitc)
                    4'd8: begin
                        case (phase)
                            PH_ADDR: begin
                                if (addr_hit && !rx[0]) begin
                                    oe    <= 1'b1;
                                    phase <= PH_CMD;
                                end else if (addr_hit && have_cmd) begin
                                    oe      <= 1'b1;
                                    phase   <= PH_RD;
                                    rd_word <= reg_rdata;
                                    blk     <= cmd[BLK_BIT];
                                end else begin
                                    if (addr_hit) err <= ERR_NOCMD;
                                    phase <= PH_IDLE;
                                end
                            end
                            PH_CMD: begin
                                oe     <= 1'b1;
                                cmd    <= rx;
                                phase  <= PH_WR;
                                wcnt   <= '0;
                                pec_ok <= 1'b0;
                            end
                            PH_WR: begin
                                case (wcnt)
                                    2'd0: begin dlo <= rx; oe <= 1'b1; end
                                    2'd1: begin dhi <= rx; oe <= 1'b1; end
                                    2'd2: begin
                                        if (rx == crc) begin
                                            oe     <= 1'b1;
                                            pec_ok <= 1'b1;
                                        end else begin
                                            err    <= ERR_PEC;
                                            pec_ok <= 1'b0;
                                        end
                                    end
                                    default: oe <= 1'b0;
                                endcase
                                if (wcnt != 2'd3) wcnt <= wcnt + 2'd1;
                            end
                            PH_RD:   oe <= 1'b0;
                            default: oe <= 1'b0;
                        endcase
                    end
                    4'd9: begin
                        bitc <= '0;
                        if (phase == PH_RD) begin
                            tx_started <= 1'b1;
                            oe         <= ~tx_byte[BYTE_W-1];
                        end else begin
                            oe <= 1'b0;
                        end
                    end
                    4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7: begin
                        if (phase == PH_RD && tx_started)
                            oe <= ~tx_byte[3'd7 - bitc[2:0]];
                    end
                    default: ;
                endcase
            end
        end
    end

    smb_reset_unlock #(
        .AW       (BYTE_W),
        .DW       (WORD_W),
        .CAL_REG  (CAL_REG),
        .CAL_KEY  (CAL_KEY),
        .EXIT_REG (EXIT_REG),
        .EXIT_KEY (EXIT_KEY)
    ) u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (we_q),
        .addr     (cmd),
        .data     ({dhi, dlo}),
        .cal_mode (cal_mode),
        .dev_rst  (dev_rst)
    );

    assign sda_oe    = oe;
    assign reg_addr  = cmd;
    assign reg_wdata = {dhi, dlo};
    assign reg_we    = we_q;
    assign err_code  = err;

    // R3: a register write is only issued right after a stop.
    a_r3_we_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> $past(stop_ev));

    // R9: the slave begins pulling the data line only while the clock is low.
    a_r9_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    // R2: with no message under way the data line is left released.
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> !sda_oe);

endmodule

// File: tb/tb_smb_pec_slave.sv
// Scoreboard bench: message tasks queue the expected register writes, and a
// monitor pops and compares them as reg_we strobes.
module tb_smb_pec_slave;
    localparam int Q = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        sda_oe;
    logic [7:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic        reg_we;
    logic [15:0] reg_rdata;
    logic [1:0]  err_code;
    logic        cal_mode;
    logic        dev_rst;
    logic        sda_bus;

    int n_chk = 0;
    int n_err = 0;
    int n_rst = 0;
    int n_wr  = 0;
    int n_viol = 0;
    logic oe_prev = 1'b0;
    logic [23:0] exp_q[$];

    always #2 clk = ~clk;

    assign sda_bus   = m_sda & ~sda_oe;
    assign reg_rdata = {reg_addr ^ 8'hA5, reg_addr + 8'h31};

    smb_pec_slave dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (m_scl),
        .sda_i     (sda_bus),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata),
        .err_code  (err_code),
        .cal_mode  (cal_mode),
        .dev_rst   (dev_rst)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] bcrc(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r;
        r = c ^ d;
        for (int k = 0; k < 8; k++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
        return r;
    endfunction

    // Monitor: scoreboard for writes, reset pulses and the drive rule (R9).
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_we) begin
                n_wr++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected write", {8'h0, reg_addr, reg_wdata}, 32'h0);
                end else begin
                    logic [23:0] e;
                    e = exp_q.pop_front();
                    chk({reg_addr, reg_wdata} == e, "R3 write content",
                        {8'h0, reg_addr, reg_wdata}, {8'h0, e});
                end
            end
            if (dev_rst) n_rst++;
            if (sda_oe && !oe_prev && m_scl) n_viol++;
            oe_prev <= sda_oe;
        end
    end

    task automatic hold();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; m_scl = 1'b1; hold();
        m_sda = 1'b0; hold();
        m_scl = 1'b0; hold();
    endtask

    task automatic bus_rstart();
        m_sda = 1'b1; hold();
        m_scl = 1'b1; hold();
        m_sda = 1'b0; hold();
        m_scl = 1'b0; hold();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; hold();
        m_scl = 1'b1; hold();
        m_sda = 1'b1; hold();
    endtask

    task automatic send(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; hold();
            m_scl = 1'b1; hold();
            m_scl = 1'b0;
        end
        hold();
        m_sda = 1'b1; hold();
        m_scl = 1'b1;
        repeat (Q / 2) @(negedge clk);
        ack = ~sda_bus;
        repeat (Q / 2) @(negedge clk);
        m_scl = 1'b0; hold();
    endtask

    task automatic recv(input bit give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hold();
            m_scl = 1'b1;
            repeat (Q / 2) @(negedge clk);
            b[i] = sda_bus;
            repeat (Q / 2) @(negedge clk);
            m_scl = 1'b0;
        end
        hold();
        m_sda = give_ack ? 1'b0 : 1'b1; hold();
        m_scl = 1'b1; hold();
        m_scl = 1'b0; hold();
        m_sda = 1'b1;
    endtask

    // Word write; mode 0 no check byte, 1 good check byte, 2 corrupted one.
    task automatic wr_word(input logic [7:0] cmd, input logic [15:0] d, input int mode,
                           output bit a_addr, output bit a_data, output bit a_pec);
        bit a1, a2, a3;
        logic [7:0] c;
        c = bcrc(8'h00, 8'h16); c = bcrc(c, cmd);
        c = bcrc(c, d[7:0]);    c = bcrc(c, d[15:8]);
        bus_start();
        send(8'h16, a_addr);
        send(cmd, a1);
        send(d[7:0], a2);
        send(d[15:8], a3);
        a_data = a1 & a2 & a3;
        a_pec = 1'b0;
        if (mode == 1) send(c, a_pec);
        if (mode == 2) send(c ^ 8'h5A, a_pec);
        if (mode != 2) exp_q.push_back({cmd, d});
        bus_stop();
        repeat (20) @(negedge clk);
    endtask

    // Read of n bytes after command cmd; the last byte is refused.
    task automatic rd_bytes(input logic [7:0] cmd, input int n, output logic [7:0] r0,
                            output logic [7:0] r1, output logic [7:0] r2,
                            output logic [7:0] r3, output bit a_rd);
        bit a0, a1;
        logic [7:0] tmp [4];
        bus_start();
        send(8'h16, a0);
        send(cmd, a1);
        bus_rstart();
        send(8'h17, a_rd);
        for (int i = 0; i < 4; i++) tmp[i] = 8'h00;
        for (int i = 0; i < n; i++) recv(i != n - 1, tmp[i]);
        bus_stop();
        r0 = tmp[0]; r1 = tmp[1]; r2 = tmp[2]; r3 = tmp[3];
        repeat (20) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        bit aa, ad, ap, ar;
        logic [7:0] b0, b1, b2, b3, e;
        int w0, r0;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(sda_oe == 1'b0, "R9 reset drive", sda_oe, 0);
        chk(reg_we == 1'b0, "R3 reset strobe", reg_we, 0);
        chk(err_code == 2'd0, "R5 reset error", err_code, 0);
        chk(cal_mode == 1'b0, "R10 reset cal", cal_mode, 0);

        // R3: plain word write.
        wr_word(8'h21, 16'hBEEF, 0, aa, ad, ap);
        chk(aa, "R2 address ack", aa, 1);
        chk(ad, "R3 data acks", ad, 1);
        chk(exp_q.size() == 0, "R3 write committed", exp_q.size(), 0);

        // R4: write with a good check byte.
        wr_word(8'h22, 16'h1357, 1, aa, ad, ap);
        chk(ap, "R4 good check byte ack", ap, 1);
        chk(exp_q.size() == 0, "R4 write committed", exp_q.size(), 0);
        chk(err_code == 2'd0, "R4 no error", err_code, 0);

        // R5: corrupted check byte.
        w0 = n_wr;
        wr_word(8'h23, 16'h4242, 2, aa, ad, ap);
        chk(!ap, "R5 bad check byte nack", ap, 0);
        chk(err_code == 2'd1, "R5 error code", err_code, 1);
        chk(n_wr == w0, "R5 no commit", n_wr, w0);

        // R2: foreign address is refused and the line stays released.
        bus_start();
        send(8'h58, aa);
        chk(!aa, "R2 foreign address nack", aa, 0);
        send(8'h00, ad);
        chk(!ad, "R2 quiet after foreign address", ad, 0);
        bus_stop();
        repeat (20) @(negedge clk);
        chk(err_code == 2'd0, "R5 error cleared by start", err_code, 0);

        // R1: a stop before the word is complete discards it.
        w0 = n_wr;
        bus_start();
        send(8'h16, aa);
        send(8'h24, ad);
        send(8'h77, ap);
        bus_stop();
        repeat (20) @(negedge clk);
        chk(n_wr == w0, "R1 partial word dropped", n_wr, w0);

        // R6: word read without check byte.
        rd_bytes(8'h30, 2, b0, b1, b2, b3, ar);
        chk(ar, "R6 read address ack", ar, 1);
        chk(b0 == 8'h61, "R6 low byte", b0, 8'h61);
        chk(b1 == 8'h95, "R6 high byte", b1, 8'h95);

        // R6: word read with check byte.
        rd_bytes(8'h41, 3, b0, b1, b2, b3, ar);
        e = bcrc(8'h00, 8'h16); e = bcrc(e, 8'h41); e = bcrc(e, 8'h17);
        e = bcrc(e, 8'h72); e = bcrc(e, 8'hE4);
        chk(b0 == 8'h72 && b1 == 8'hE4, "R6 word data", {b1, b0}, 16'hE472);
        chk(b2 == e, "R6 returned check byte", b2, e);

        // R7: block read.
        rd_bytes(8'h85, 4, b0, b1, b2, b3, ar);
        e = bcrc(8'h00, 8'h16); e = bcrc(e, 8'h85); e = bcrc(e, 8'h17);
        e = bcrc(e, 8'h02); e = bcrc(e, 8'hB6); e = bcrc(e, 8'h20);
        chk(b0 == 8'h02, "R7 byte count", b0, 2);
        chk(b1 == 8'hB6 && b2 == 8'h20, "R7 block data", {b2, b1}, 16'h20B6);
        chk(b3 == e, "R7 check byte", b3, e);

        // R8: read address with no command.
        bus_start();
        send(8'h17, ar);
        bus_stop();
        repeat (20) @(negedge clk);
        chk(!ar, "R8 read without command nack", ar, 0);
        chk(err_code == 2'd2, "R8 error code", err_code, 2);

        // R10: unlock then reset.
        r0 = n_rst;
        wr_word(8'h00, 16'h0653, 0, aa, ad, ap);
        chk(cal_mode == 1'b1, "R10 enter cal", cal_mode, 1);
        wr_word(8'h5E, 16'h0000, 1, aa, ad, ap);
        chk(n_rst == r0 + 1, "R10 reset pulse", n_rst, r0 + 1);
        chk(cal_mode == 1'b0, "R10 cal cleared", cal_mode, 0);

        // R11: an intervening write aborts the sequence.
        wr_word(8'h00, 16'h0653, 0, aa, ad, ap);
        chk(cal_mode == 1'b1, "R11 enter cal", cal_mode, 1);
        wr_word(8'h10, 16'h1234, 0, aa, ad, ap);
        chk(cal_mode == 1'b0, "R11 aborted", cal_mode, 0);
        wr_word(8'h5E, 16'h0000, 0, aa, ad, ap);
        chk(n_rst == r0 + 1, "R11 no reset pulse", n_rst, r0 + 1);
        chk(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);

        chk(n_viol == 0, "R9 drive began with clock high", n_viol, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule